// File: doc/BRIEF.md
# Speculative In-Order Store Buffer

This block is a ring of store entries that sits between the execution of store operations and their write into the data cache. The issue stage claims an entry for each store in program order. The entry index goes back with the store so that the address half and the data half can be written later, each by its own operation and in either order. A store becomes eligible for the cache only after the retirement logic declares it non-speculative. From then on the buffer hands entries to a single cache write port, oldest first, one per grant.

When a misprediction or exception is detected, the flush input for a hardware thread throws away every entry of that thread that has not yet retired. Entries that have already retired are certain to happen, so they stay and still reach the cache. A per-thread drained flag lets fence and atomic sequencing wait until that thread has nothing left in flight. The flag only reports state and removes nothing.

When two hardware threads are configured, the ring is cut statically into two equal halves. Each thread allocates, retires, flushes and commits only inside its own half. A round-robin choice shares the one commit port between the threads.

Top module: `store_commit_ring`

## Requirements
- R1: Each thread hands out entries in program order. The entry index is `tid*(DEPTH/THREADS)` plus a local position that starts at 0 after reset, advances by one per accepted allocation and wraps after `DEPTH/THREADS-1`. `alloc_ready[t]` is low while thread t holds `DEPTH/THREADS` entries, and an allocation presented while it is low is ignored.
- R2: The address with its size code and the data of an entry are written by separate operations addressed by entry index, in either order. An entry is offered on the commit port only after both have arrived, and the port shows the values written.
- R3: A store takes exactly one entry whatever its 2-bit size code. The size code is only carried to `cm_size`.
- R4: Only retired entries are offered for commit, and each thread's entries leave strictly oldest first. While `cm_valid` is high and `cm_grant` is low, the offered entry stays in place.
- R5: A retire for thread t marks that thread's oldest unretired entry as retired. A retire while thread t has no unretired entry is ignored.
- R6: A flush for thread t discards all of t's unretired entries in one cycle and keeps its retired ones. A retire for t in the same cycle takes effect first. `alloc_ready[t]` is low during a flush cycle for t.
- R7: Each thread stays within its own half of the entry indices, and activity on one thread never changes the other thread's entries.
- R8: When both threads offer a committable entry, the port goes to the thread that was not granted most recently. After reset, thread 0 counts as preferred.
- R9: `drained[t]` is high, combinationally, exactly when thread t holds no entry, retired or not.
- R10: After reset all entries are free. Every `drained` and `alloc_ready` bit is high and `cm_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request from issue |
| alloc_tid | input | TW | Thread of the allocation |
| alloc_ready | output | THREADS | Per-thread room for an allocation |
| alloc_idx | output | GW | Entry index given to the allocating store |
| aw_valid | input | 1 | Address write strobe |
| aw_idx | input | GW | Entry receiving the address |
| aw_addr | input | AW | Store address |
| aw_size | input | 2 | Store size code |
| dw_valid | input | 1 | Data write strobe |
| dw_idx | input | GW | Entry receiving the data |
| dw_data | input | DW | Store data |
| retire_valid | input | 1 | Oldest unretired store of a thread retires |
| retire_tid | input | TW | Thread of the retire |
| flush_valid | input | 1 | Discard speculative stores of a thread |
| flush_tid | input | TW | Thread of the flush |
| cm_valid | output | 1 | An entry is offered to the cache |
| cm_tid | output | TW | Thread of the offered entry |
| cm_addr | output | AW | Address of the offered entry |
| cm_size | output | 2 | Size code of the offered entry |
| cm_data | output | DW | Data of the offered entry |
| cm_grant | input | 1 | Cache accepts the offered entry |
| drained | output | THREADS | Thread holds no entries |

## Verification
The bench builds the block with two threads and a depth of 8, which leaves four entries per thread. With so few entries, a full half, pointer wrap-around and a flush that lands on a partly retired window all occur within a few dozen cycles. Random phases mix address-first and data-first fills, retires with nothing left to retire, flushes that coincide with retires, and stretches with the grant held low. A final drain phase retires and commits everything, so both drained flags must return high.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Next local position in a ring of pd slots.
  function automatic int next_slot(input int idx, input int pd);
    return (idx == pd - 1) ? 0 : idx + 1;
  endfunction

  // Whether stepping from idx crosses the end of the ring.
  function automatic bit crosses_end(input int idx, input int pd);
    return idx == pd - 1;
  endfunction

  // Number of slots from position a to position b, using the lap bits.
  function automatic int span(input int a_idx, input bit a_lap,
                              input int b_idx, input bit b_lap, input int pd);
    return (a_lap == b_lap) ? (b_idx - a_idx) : (b_idx + pd - a_idx);
  endfunction

  // Global entry index from thread number and local position.
  function automatic int global_slot(input int tid, input int local_idx, input int pd);
    return tid * pd + local_idx;
  endfunction

endpackage

// File: rtl/sbuf_lane.sv
module sbuf_lane #(
  parameter int PD = 28,
  localparam int IW = (PD > 1) ? $clog2(PD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_fire,
  input  logic          retire_req,
  input  logic          flush_req,
  input  logic          commit_fire,
  output logic [IW-1:0] head_idx,
  output logic [IW-1:0] tail_idx,
  output logic          full,
  output logic          empty,
  output logic          head_retired
);
  import sbuf_pkg::*;

  logic [IW-1:0] hd_i, rt_i, tl_i;
  logic          hd_w, rt_w, tl_w;
  logic [IW-1:0] rt_i_nx;
  logic          rt_w_nx;
  logic          retire_fire;

  // Boundary between retired and speculative entries.
  assign retire_fire = retire_req && !((rt_i == tl_i) && (rt_w == tl_w));

  always_comb begin
    rt_i_nx = rt_i;
    rt_w_nx = rt_w;
    if (retire_fire) begin
      rt_i_nx = IW'(next_slot(int'(rt_i), PD));
      rt_w_nx = rt_w ^ crosses_end(int'(rt_i), PD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_i <= '0; hd_w <= 1'b0;
      rt_i <= '0; rt_w <= 1'b0;
      tl_i <= '0; tl_w <= 1'b0;
    end else begin
      rt_i <= rt_i_nx;
      rt_w <= rt_w_nx;
      if (commit_fire) begin
        hd_i <= IW'(next_slot(int'(hd_i), PD));
        hd_w <= hd_w ^ crosses_end(int'(hd_i), PD);
      end
      if (flush_req) begin
        tl_i <= rt_i_nx;
        tl_w <= rt_w_nx;
      end else if (alloc_fire) begin
        tl_i <= IW'(next_slot(int'(tl_i), PD));
        tl_w <= tl_w ^ crosses_end(int'(tl_i), PD);
      end
    end
  end

  assign head_idx     = hd_i;
  assign tail_idx     = tl_i;
  assign empty        = (hd_i == tl_i) && (hd_w == tl_w);
  assign full         = (hd_i == tl_i) && (hd_w != tl_w);
  assign head_retired = !((hd_i == rt_i) && (hd_w == rt_w));

  // R1: occupancy never exceeds the half
  p_no_overfill_r1: assert property (@(posedge clk) disable iff (!rst_n)
    span(int'(hd_i), hd_w, int'(tl_i), tl_w, PD) <= PD);

  // R5: the retire boundary stays inside the occupied window
  p_retire_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    span(int'(hd_i), hd_w, int'(rt_i), rt_w, PD) <= span(int'(hd_i), hd_w, int'(tl_i), tl_w, PD));

  // R6: after a flush no speculative entry is left
  p_flush_drops_young_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (rt_i == tl_i) && (rt_w == tl_w));

  // R4: the head moves only on a granted commit
  p_head_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_fire |=> $stable(hd_i) && $stable(hd_w));

  // R9: an empty thread has nothing retired pending
  p_drained_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !head_retired);

endmodule

// File: rtl/sbuf_slots.sv
module sbuf_slots #(
  parameter int DEPTH = 56,
  parameter int AW = 48,
  parameter int DW = 64,
  parameter int SW = 2,
  localparam int GW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic [GW-1:0]    clr_idx,
  input  logic             a_we,
  input  logic [GW-1:0]    a_idx,
  input  logic [AW-1:0]    a_val,
  input  logic [SW-1:0]    s_val,
  input  logic             d_we,
  input  logic [GW-1:0]    d_idx,
  input  logic [DW-1:0]    d_val,
  input  logic [GW-1:0]    rd_idx,
  output logic [DEPTH-1:0] av_q,
  output logic [DEPTH-1:0] dv_q,
  output logic [AW-1:0]    rd_addr,
  output logic [SW-1:0]    rd_size,
  output logic [DW-1:0]    rd_data
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [SW-1:0] size_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      av_q <= '0;
      dv_q <= '0;
    end else begin
      if (clr_en) begin
        av_q[clr_idx] <= 1'b0;
        dv_q[clr_idx] <= 1'b0;
      end
      if (a_we) av_q[a_idx] <= 1'b1;
      if (d_we) dv_q[d_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (a_we) begin
      addr_q[a_idx] <= a_val;
      size_q[a_idx] <= s_val;
    end
    if (d_we) data_q[d_idx] <= d_val;
  end

  assign rd_addr = addr_q[rd_idx];
  assign rd_size = size_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  // R2: a new entry starts with neither half present
  p_alloc_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !(a_we && a_idx == clr_idx) && !(d_we && d_idx == clr_idx)
      |=> !av_q[$past(clr_idx)] && !dv_q[$past(clr_idx)]);

  // R2: address and data halves are recorded independently
  p_addr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> av_q[$past(a_idx)]);
  p_data_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    d_we |=> dv_q[$past(d_idx)]);

endmodule

// File: rtl/sbuf_pick.sv
module sbuf_pick #(
  parameter int NT = 2,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] cand,
  input  logic          grant,
  output logic [TW-1:0] sel,
  output logic          any
);
  generate
    if (NT == 1) begin : g_single
      assign sel = '0;
      assign any = cand[0];
    end else begin : g_pair
      logic last_q;
      always_comb begin
        if (cand == 2'b11) sel = TW'(~last_q);
        else               sel = TW'(cand[1]);
      end
      assign any = |cand;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            last_q <= 1'b1;
        else if (any && grant) last_q <= sel[0];
      end

      // R8: back-to-back contested grants alternate
      p_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (any && grant && cand == 2'b11) |=> (cand != 2'b11 || sel != $past(sel)));
    end
  endgenerate
endmodule

// File: rtl/store_commit_ring.sv
module store_commit_ring #(
  parameter int DEPTH   = 56,
  parameter int THREADS = 2,
  parameter int AW      = 48,
  parameter int DW      = 64,
  localparam int SW = 2,
  localparam int PD = DEPTH / THREADS,
  localparam int IW = (PD > 1) ? $clog2(PD) : 1,
  localparam int GW = $clog2(DEPTH),
  localparam int TW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [TW-1:0]      alloc_tid,
  output logic [THREADS-1:0] alloc_ready,
  output logic [GW-1:0]      alloc_idx,
  input  logic               aw_valid,
  input  logic [GW-1:0]      aw_idx,
  input  logic [AW-1:0]      aw_addr,
  input  logic [SW-1:0]      aw_size,
  input  logic               dw_valid,
  input  logic [GW-1:0]      dw_idx,
  input  logic [DW-1:0]      dw_data,
  input  logic               retire_valid,
  input  logic [TW-1:0]      retire_tid,
  input  logic               flush_valid,
  input  logic [TW-1:0]      flush_tid,
  output logic               cm_valid,
  output logic [TW-1:0]      cm_tid,
  output logic [AW-1:0]      cm_addr,
  output logic [SW-1:0]      cm_size,
  output logic [DW-1:0]      cm_data,
  input  logic               cm_grant,
  output logic [THREADS-1:0] drained
);
  import sbuf_pkg::*;

  logic [THREADS-1:0] alloc_fire, retire_hit, flush_hit, commit_fire;
  logic [THREADS-1:0] full, empty, head_retired, cand;
  logic [IW-1:0]      head_loc [THREADS];
  logic [IW-1:0]      tail_loc [THREADS];
  logic [GW-1:0]      head_glob [THREADS];
  logic [GW-1:0]      tail_glob [THREADS];
  logic [DEPTH-1:0]   av_q, dv_q;
  logic [GW-1:0]      rd_idx;
  logic [TW-1:0]      sel;
  logic               any;

  generate
    for (genvar t = 0; t < THREADS; t++) begin : g_lane
      assign retire_hit[t]  = retire_valid && (retire_tid == TW'(t));
      assign flush_hit[t]   = flush_valid && (flush_tid == TW'(t));
      assign alloc_ready[t] = !full[t] && !flush_hit[t];
      assign alloc_fire[t]  = alloc_valid && (alloc_tid == TW'(t)) && alloc_ready[t];
      assign head_glob[t]   = GW'(global_slot(t, int'(head_loc[t]), PD));
      assign tail_glob[t]   = GW'(global_slot(t, int'(tail_loc[t]), PD));
      assign cand[t]        = head_retired[t] && av_q[head_glob[t]] && dv_q[head_glob[t]];
      assign commit_fire[t] = any && cm_grant && (sel == TW'(t));
      assign drained[t]     = empty[t];

      sbuf_lane #(.PD(PD)) u_lane (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_fire   (alloc_fire[t]),
        .retire_req   (retire_hit[t]),
        .flush_req    (flush_hit[t]),
        .commit_fire  (commit_fire[t]),
        .head_idx     (head_loc[t]),
        .tail_idx     (tail_loc[t]),
        .full         (full[t]),
        .empty        (empty[t]),
        .head_retired (head_retired[t])
      );
    end

    if (THREADS == 1) begin : g_one
      assign alloc_idx = tail_glob[0];
      assign rd_idx    = head_glob[0];
    end else begin : g_many
      assign alloc_idx = tail_glob[alloc_tid];
      assign rd_idx    = head_glob[sel];
    end
  endgenerate

  sbuf_slots #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SW(SW)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_en  (|alloc_fire),
    .clr_idx (alloc_idx),
    .a_we    (aw_valid),
    .a_idx   (aw_idx),
    .a_val   (aw_addr),
    .s_val   (aw_size),
    .d_we    (dw_valid),
    .d_idx   (dw_idx),
    .d_val   (dw_data),
    .rd_idx  (rd_idx),
    .av_q    (av_q),
    .dv_q    (dv_q),
    .rd_addr (cm_addr),
    .rd_size (cm_size),
    .rd_data (cm_data)
  );

  sbuf_pick #(.NT(THREADS)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .cand  (cand),
    .grant (cm_grant),
    .sel   (sel),
    .any   (any)
  );

  assign cm_valid = any;
  assign cm_tid   = sel;

  // R4: an offered entry that is not granted is still offered next cycle
  p_offer_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_grant && !flush_valid |=> cm_valid);

  // R7: at most one thread allocates in a cycle
  p_single_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_fire));

endmodule

// File: tb/store_commit_ring_test.sv
module store_commit_ring_test;
  localparam int DEPTH = 8;
  localparam int NT    = 2;
  localparam int PD    = DEPTH / NT;
  localparam int AW    = 16;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0; logic [0:0] alloc_tid = 0;
  logic [1:0] alloc_ready; logic [2:0] alloc_idx;
  logic aw_valid = 0; logic [2:0] aw_idx = 0; logic [AW-1:0] aw_addr = 0; logic [1:0] aw_size = 0;
  logic dw_valid = 0; logic [2:0] dw_idx = 0; logic [DW-1:0] dw_data = 0;
  logic retire_valid = 0; logic [0:0] retire_tid = 0;
  logic flush_valid = 0; logic [0:0] flush_tid = 0;
  logic cm_valid; logic [0:0] cm_tid; logic [AW-1:0] cm_addr; logic [1:0] cm_size; logic [DW-1:0] cm_data;
  logic cm_grant = 0;
  logic [1:0] drained;

  always #5 clk = ~clk;

  store_commit_ring #(.DEPTH(DEPTH), .THREADS(NT), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tid(alloc_tid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .aw_valid(aw_valid), .aw_idx(aw_idx), .aw_addr(aw_addr), .aw_size(aw_size),
    .dw_valid(dw_valid), .dw_idx(dw_idx), .dw_data(dw_data),
    .retire_valid(retire_valid), .retire_tid(retire_tid),
    .flush_valid(flush_valid), .flush_tid(flush_tid),
    .cm_valid(cm_valid), .cm_tid(cm_tid), .cm_addr(cm_addr), .cm_size(cm_size), .cm_data(cm_data),
    .cm_grant(cm_grant), .drained(drained));

  // Behavioural reference: per-thread program-order queues of entry indices.
  int q [2][$];
  int nret [2];
  int tl [2];
  bit m_av [DEPTH]; bit m_dv [DEPTH];
  int m_addr [DEPTH]; int m_data [DEPTH]; int m_size [DEPTH];
  int last;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic bit e_cand(int t);
    if (nret[t] == 0) return 0;
    return m_av[q[t][0]] && m_dv[q[t][0]];
  endfunction
  function automatic bit e_valid();
    return e_cand(0) || e_cand(1);
  endfunction
  function automatic int e_sel();
    if (e_cand(0) && e_cand(1)) return 1 - last;
    return e_cand(1) ? 1 : 0;
  endfunction
  function automatic bit e_ready(int t);
    return (q[t].size() < PD) && !(flush_valid && int'(flush_tid) == t);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin q[t].delete(); nret[t] = 0; tl[t] = 0; end
      for (int i = 0; i < DEPTH; i++) begin m_av[i] = 0; m_dv[i] = 0; end
      last = 1;
    end else begin
      bit cv, afire; int cs, at, unret_r, rt, ft;
      cv = e_valid(); cs = e_sel();
      at = int'(alloc_tid);
      afire = alloc_valid && e_ready(at);
      rt = int'(retire_tid);
      unret_r = q[rt].size() - nret[rt];
      if (aw_valid) begin m_av[aw_idx] = 1; m_addr[aw_idx] = int'(aw_addr); m_size[aw_idx] = int'(aw_size); end
      if (dw_valid) begin m_dv[dw_idx] = 1; m_data[dw_idx] = int'(dw_data); end
      if (cv && cm_grant) begin void'(q[cs].pop_front()); nret[cs]--; last = cs; end
      if (retire_valid && unret_r > 0) nret[rt]++;
      if (flush_valid) begin
        ft = int'(flush_tid);
        while (q[ft].size() > nret[ft]) begin
          void'(q[ft].pop_back());
          tl[ft] = (tl[ft] + PD - 1) % PD;
        end
      end
      if (afire) begin
        int g;
        g = at * PD + tl[at];
        q[at].push_back(g);
        tl[at] = (tl[at] + 1) % PD;
        m_av[g] = 0; m_dv[g] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int t = 0; t < 2; t++) begin
      chk(alloc_ready[t] == e_ready(t), $sformatf("R1/R6/R7 alloc_ready[%0d]", t), alloc_ready[t], e_ready(t));
      chk(drained[t] == (q[t].size() == 0), $sformatf("R9 drained[%0d]", t), drained[t], q[t].size() == 0);
    end
    chk(alloc_idx == 3'(int'(alloc_tid) * PD + tl[alloc_tid]), "R1/R3/R7 alloc_idx",
        alloc_idx, int'(alloc_tid) * PD + tl[alloc_tid]);
    chk(cm_valid == e_valid(), "R2/R4/R5/R6 cm_valid", cm_valid, e_valid());
    if (cm_valid && e_valid()) begin
      int h;
      h = q[e_sel()][0];
      chk(int'(cm_tid) == e_sel(), "R8 cm_tid", cm_tid, e_sel());
      chk(int'(cm_addr) == m_addr[h], "R2/R4 cm_addr", cm_addr, m_addr[h]);
      chk(int'(cm_data) == m_data[h], "R2/R4 cm_data", cm_data, m_data[h]);
      chk(int'(cm_size) == m_size[h], "R3 cm_size", cm_size, m_size[h]);
    end
  endtask

  // One cycle of stimulus; percentages steer each kind of event.
  task automatic step(input int p_alloc, input int p_tid1, input int p_wr,
                      input int p_ret, input int p_flush, input int p_grant);
    int na, nd; int ca [$]; int cd [$];
    @(negedge clk);
    alloc_valid = ($urandom_range(99) < p_alloc);
    alloc_tid   = ($urandom_range(99) < p_tid1);
    for (int t = 0; t < 2; t++)
      foreach (q[t][i]) begin
        if (!m_av[q[t][i]]) ca.push_back(q[t][i]);
        if (!m_dv[q[t][i]]) cd.push_back(q[t][i]);
      end
    na = ca.size(); nd = cd.size();
    aw_valid = (na > 0) && ($urandom_range(99) < p_wr);
    if (aw_valid) begin
      aw_idx = 3'(ca[$urandom_range(na - 1)]);
      aw_addr = AW'($urandom); aw_size = 2'($urandom);
    end
    dw_valid = (nd > 0) && ($urandom_range(99) < p_wr);
    if (dw_valid) begin dw_idx = 3'(cd[$urandom_range(nd - 1)]); dw_data = DW'($urandom); end
    retire_valid = ($urandom_range(99) < p_ret);
    retire_tid   = 1'($urandom);
    flush_valid  = ($urandom_range(99) < p_flush);
    flush_tid    = 1'($urandom);
    cm_grant     = ($urandom_range(99) < p_grant);
    #1;
    compare_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R10: reset state
    chk(alloc_ready == 2'b11, "R10 alloc_ready after reset", alloc_ready, 3);
    chk(drained == 2'b11, "R10 drained after reset", drained, 3);
    chk(cm_valid == 1'b0, "R10 cm_valid after reset", cm_valid, 0);
    // R1: fill thread 0 beyond its half with no retire, no writes
    for (int i = 0; i < 8; i++) step(100, 0, 0, 0, 0, 0);
    chk(alloc_ready[0] == 1'b0, "R1 thread 0 full", alloc_ready[0], 0);
    chk(drained[1] == 1'b1, "R7 thread 1 untouched", drained[1], 1);
    // R2: fill halves but keep entries speculative, nothing may commit
    for (int i = 0; i < 20; i++) step(0, 0, 60, 0, 0, 100);
    chk(cm_valid == 1'b0, "R4 no commit before retire", cm_valid, 0);
    // R5/R6: retire some, flush the rest
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 10; i++) step(60, 50, 70, 40, 10, 30);
    // mixed random phases
    for (int i = 0; i < 1500; i++) step(50, 50, 60, 40, 3, 50);
    for (int i = 0; i < 800; i++)  step(80, 30, 40, 60, 8, 20);
    for (int i = 0; i < 800; i++)  step(40, 70, 90, 70, 1, 90);
    // R9: drain everything, both drained flags must rise
    for (int i = 0; i < 200 && (q[0].size() + q[1].size()) > 0; i++) step(0, 0, 100, 100, 0, 100);
    step(0, 0, 0, 0, 0, 0);
    chk(drained == 2'b11, "R9 drained after full drain", drained, 3);
    chk(cm_valid == 1'b0, "R4 idle after drain", cm_valid, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule